// File: doc/BRIEF.md
# Pin-Limited Byte Register Processor

A single-cycle 8-bit processor core with sixteen general registers, an arithmetic/logic unit and a carry flag, reached only through three byte-wide ports. An instruction byte arrives on the instruction pins every clock. Its upper nibble is the opcode and its lower nibble names the destination register. A shared byte port carries one of two things. For a load it carries the data byte. For other instructions it carries two source register addresses: the first source in its upper nibble and the second source in its lower nibble. The shared port is modelled as an input bus plus an output-enable that stays low.

The processor has no program counter and no instruction memory. Whatever drives the pins acts as the program sequencer. Every instruction completes at the clock edge on which it is sampled. Register writes, the carry flag and the registered output byte all take their new values at that same edge. The output byte shows either the contents of a register or the processor status.

Top module: `byte_reg_cpu`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers, the carry flag and the output byte to zero.
- R2: Opcode 0001 writes the whole shared-port byte into the register named by instruction bits 3:0.
- R3: Opcode 0010 places the named register on the output byte after the clock edge. Every other opcode except 0011 leaves the output byte unchanged.
- R4: Opcode 0000 copies the register named by shared-port bits 7:4 into the register named by instruction bits 3:0.
- R5: Opcode 0011 places the carry flag on output bit 0 and drives output bits 7:1 to zero.
- R6: Opcodes 1000 (NOT of first source), 1001 (AND), 1010 (OR) and 1101 (XOR) write the result to the destination register and clear the carry flag.
- R7: Opcode 1011 writes first source plus second source, modulo 256, to the destination. The carry flag takes the carry out of bit 7.
- R8: Opcode 1100 writes first source minus second source, modulo 256, to the destination. The carry flag is set to 1 when no borrow occurs, that is when first source >= second source.
- R9: Opcode 1110 writes the first source plus one to the destination. The carry flag takes the carry out of bit 7.
- R10: Opcodes 0100 to 0111 and 1111 change no register, the carry flag or the output byte.
- R11: The carry flag changes only on ALU opcodes. The shared-port output-enable is always low.
- R12: When the destination is also a source, the operation reads the value the register held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instrIn | input | 8 | Opcode in bits 7:4, destination register in bits 3:0 |
| portIn | input | 8 | Shared port input: load data, or first source (7:4) and second source (3:0) |
| outByte | output | 8 | Registered output: register data or status |
| portOe | output | 1 | Output-enable of the shared port, held low |

## Verification
The bench builds the block with its default data width of 8. This gives a 4-bit register address, so both nibbles of the shared port and all sixteen registers are within reach of the stimulus. Carry boundaries are reachable at this width: 0xFF increment, equal-operand subtract and sums that overflow by exactly one. Directed sequences cover these cases, aliasing of destination and source, and the no-operation codes. A long random instruction stream then drives the behavioural model and the core side by side.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_MOVE   = 4'b0000;
  localparam logic [OP_W-1:0] OP_LOAD   = 4'b0001;
  localparam logic [OP_W-1:0] OP_STORE  = 4'b0010;
  localparam logic [OP_W-1:0] OP_STATUS = 4'b0011;

  typedef enum logic [2:0] {
    ALU_NOT  = 3'd0,
    ALU_AND  = 3'd1,
    ALU_OR   = 3'd2,
    ALU_ADD  = 3'd3,
    ALU_SUB  = 3'd4,
    ALU_XOR  = 3'd5,
    ALU_INC  = 3'd6,
    ALU_NONE = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    WR_MOVE = 2'd0,
    WR_LOAD = 2'd1,
    WR_ALU  = 2'd2
  } wrSel_e;

  typedef struct packed {
    logic   regWe;
    wrSel_e wrSel;
    logic   outFromReg;
    logic   outFromStatus;
    logic   carryWe;
    aluOp_e aluOp;
  } ctrl_t;

endpackage

// File: rtl/cpu_control.sv
module cpu_control
  import cpu_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctrl_t           ctrl
);

  logic isAlu;
  assign isAlu = opcode[OP_W-1] && (opcode[2:0] != 3'b111);

  always_comb begin
    ctrl               = '0;
    ctrl.wrSel         = WR_MOVE;
    ctrl.aluOp         = aluOp_e'(opcode[2:0]);
    if (isAlu) begin
      ctrl.regWe   = 1'b1;
      ctrl.wrSel   = WR_ALU;
      ctrl.carryWe = 1'b1;
    end else begin
      case (opcode)
        OP_MOVE: begin
          ctrl.regWe = 1'b1;
          ctrl.wrSel = WR_MOVE;
        end
        OP_LOAD: begin
          ctrl.regWe = 1'b1;
          ctrl.wrSel = WR_LOAD;
        end
        OP_STORE:  ctrl.outFromReg    = 1'b1;
        OP_STATUS: ctrl.outFromStatus = 1'b1;
        default:   ctrl.regWe         = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluOp_e            op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);

  localparam logic [DATA_W:0] ONE = {{DATA_W{1'b0}}, 1'b1};

  logic [DATA_W:0] wide;

  always_comb begin
    wide     = '0;
    result   = '0;
    carryOut = 1'b0;
    case (op)
      ALU_NOT: result = ~opA;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_XOR: result = opA ^ opB;
      ALU_ADD: begin
        wide     = {1'b0, opA} + {1'b0, opB};
        result   = wide[DATA_W-1:0];
        carryOut = wide[DATA_W];
      end
      ALU_SUB: begin
        wide     = {1'b0, opA} + {1'b0, ~opB} + ONE;
        result   = wide[DATA_W-1:0];
        carryOut = wide[DATA_W];
      end
      ALU_INC: begin
        wide     = {1'b0, opA} + ONE;
        result   = wide[DATA_W-1:0];
        carryOut = wide[DATA_W];
      end
      default: begin
        result   = '0;
        carryOut = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [DATA_W-1:0] portIn,
  output logic [DATA_W-1:0] outByte,
  output logic              carryFlag
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [DEPTH];
  logic [ADDR_W-1:0] srcAAddr, srcBAddr;
  logic [DATA_W-1:0] srcA, srcB, dstData, aluRes, wrData;
  logic              aluCarry;
  logic [DEPTH-1:0]  wrHit;

  assign srcAAddr = portIn[DATA_W-1 -: ADDR_W];
  assign srcBAddr = portIn[ADDR_W-1:0];
  assign srcA     = regs[srcAAddr];
  assign srcB     = regs[srcBAddr];
  assign dstData  = regs[dstAddr];

  cpu_alu #(.DATA_W(DATA_W)) alu_i (
    .op       (ctrl.aluOp),
    .opA      (srcA),
    .opB      (srcB),
    .result   (aluRes),
    .carryOut (aluCarry)
  );

  always_comb begin
    case (ctrl.wrSel)
      WR_LOAD: wrData = portIn;
      WR_ALU:  wrData = aluRes;
      default: wrData = srcA;
    endcase
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_wrDecode
    assign wrHit[g] = ctrl.regWe && (dstAddr == ADDR_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst)           regs[i] <= '0;
      else if (wrHit[i]) regs[i] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carryFlag <= 1'b0;
      outByte   <= '0;
    end else begin
      if (ctrl.carryWe)            carryFlag <= aluCarry;
      if (ctrl.outFromReg)         outByte   <= dstData;
      else if (ctrl.outFromStatus) outByte   <= {{(DATA_W-1){1'b0}}, carryFlag};
    end
  end

endmodule

// File: rtl/byte_reg_cpu.sv
module byte_reg_cpu
  import cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] instrIn,
  input  logic [DATA_W-1:0] portIn,
  output logic [DATA_W-1:0] outByte,
  output logic              portOe
);

  localparam int ADDR_W = DATA_W - OP_W;

  ctrl_t ctrl;
  logic  carryFlag;

  assign portOe = 1'b0;

  cpu_control control_i (
    .opcode (instrIn[DATA_W-1 -: OP_W]),
    .ctrl   (ctrl)
  );

  cpu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) datapath_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .dstAddr   (instrIn[ADDR_W-1:0]),
    .portIn    (portIn),
    .outByte   (outByte),
    .carryFlag (carryFlag)
  );

endmodule

// File: rtl/cpu_checker.sv
module cpu_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] instrIn,
  input logic [DATA_W-1:0] outByte,
  input logic              portOe,
  input logic              carryFlag
);

  logic [3:0] op;
  assign op = instrIn[DATA_W-1 -: 4];

  logic isNop, isLogic;
  assign isNop   = (op[3:2] == 2'b01) || (op == 4'b1111);
  assign isLogic = (op == 4'b1000) || (op == 4'b1001) || (op == 4'b1010) || (op == 4'b1101);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (outByte == '0) && !carryFlag);

  // R11
  a_r11_oe_low: assert property (@(posedge clk) disable iff (rst) !portOe);

  // R11
  a_r11_carry_hold: assert property (@(posedge clk) disable iff (rst)
    !op[3] |=> $stable(carryFlag));

  // R3
  a_r3_out_hold: assert property (@(posedge clk) disable iff (rst)
    (op != 4'b0010 && op != 4'b0011) |=> $stable(outByte));

  // R5
  a_r5_status_shape: assert property (@(posedge clk) disable iff (rst)
    (op == 4'b0011) |=> (outByte[DATA_W-1:1] == '0) && (outByte[0] == $past(carryFlag)));

  // R6
  a_r6_logic_clears_carry: assert property (@(posedge clk) disable iff (rst)
    isLogic |=> !carryFlag);

  // R10
  a_r10_nop_quiet: assert property (@(posedge clk) disable iff (rst)
    isNop |=> $stable(outByte) && $stable(carryFlag));

endmodule

bind byte_reg_cpu cpu_checker #(.DATA_W(DATA_W)) checker_i (
  .clk       (clk),
  .rst       (rst),
  .instrIn   (instrIn),
  .outByte   (outByte),
  .portOe    (portOe),
  .carryFlag (carryFlag)
);

// File: tb/byte_reg_cpu_tb_top.sv
module byte_reg_cpu_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] instrIn = 8'h40;
  logic [7:0] portIn  = 8'h00;
  logic [7:0] outByte;
  logic       portOe;

  int checks = 0;
  int fails  = 0;

  int mRegs [16];
  int mCarry;
  int mOut;

  always #2 clk = ~clk;

  byte_reg_cpu dut_i (
    .clk     (clk),
    .rst     (rst),
    .instrIn (instrIn),
    .portIn  (portIn),
    .outByte (outByte),
    .portOe  (portOe)
  );

  function automatic void modelApply(input int instr, input int port);
    int op, d, a, b, va, vb, r;
    op = (instr >> 4) & 15;
    d  = instr & 15;
    a  = (port >> 4) & 15;
    b  = port & 15;
    va = mRegs[a];
    vb = mRegs[b];
    case (op)
      0:  mRegs[d] = va;
      1:  mRegs[d] = port & 255;
      2:  mOut = mRegs[d];
      3:  mOut = mCarry;
      8:  begin mRegs[d] = (~va) & 255; mCarry = 0; end
      9:  begin mRegs[d] = va & vb; mCarry = 0; end
      10: begin mRegs[d] = va | vb; mCarry = 0; end
      13: begin mRegs[d] = va ^ vb; mCarry = 0; end
      11: begin r = va + vb; mRegs[d] = r & 255; mCarry = (r > 255) ? 1 : 0; end
      12: begin mRegs[d] = (va - vb) & 255; mCarry = (va >= vb) ? 1 : 0; end
      14: begin r = va + 1; mRegs[d] = r & 255; mCarry = (r > 255) ? 1 : 0; end
      default: ;
    endcase
  endfunction

  task automatic compare(input string req);
    checks++;
    if (outByte !== 8'(mOut) || portOe !== 1'b0) begin
      fails++;
      $display("FAIL %s: outByte=%h portOe=%b expected outByte=%h portOe=0",
               req, outByte, portOe, 8'(mOut));
    end
  endtask

  task automatic step(input logic [7:0] instr, input logic [7:0] port, input string req);
    instrIn = instr;
    portIn  = port;
    modelApply(int'(instr), int'(port));
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic showReg(input int idx, input string req);
    step({4'b0010, 4'(idx)}, 8'h00, req);
  endtask

  task automatic showCarry(input string req);
    step(8'h30, 8'h00, req);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mRegs[i] = 0;
    mCarry = 0;
    mOut   = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R1 output after reset");
    showCarry("R1 carry after reset");
    for (int i = 0; i < 16; i++) showReg(i, "R1 register after reset");

    // R2 load, R3 store
    step(8'h11, 8'h5A, "R2 load r1");
    step(8'h12, 8'hC3, "R2 load r2");
    showReg(1, "R3 store r1");
    step(8'h1F, 8'h99, "R3 load leaves output");
    showReg(15, "R2 load into r15");
    // R4 move
    step(8'h03, 8'h10, "R4 move r1 to r3");
    showReg(3, "R4 moved value");
    // R7 add with carry
    step(8'hB4, 8'h12, "R7 add r4=r1+r2");
    showReg(4, "R7 add sum");
    showCarry("R7 add carry");
    // R11 carry holds across non-ALU ops
    step(8'h19, 8'h00, "R11 load keeps carry");
    step(8'h0A, 8'h40, "R11 move keeps carry");
    showCarry("R11 carry held");
    // R10 no-ops
    showReg(4, "R10 prime output");
    step(8'h4B, 8'hFF, "R10 nop 0100");
    step(8'h55, 8'h12, "R10 nop 0101");
    step(8'h66, 8'h12, "R10 nop 0110");
    step(8'h77, 8'h12, "R10 nop 0111");
    step(8'hF4, 8'h12, "R10 nop 1111");
    showReg(4, "R10 register untouched");
    showCarry("R10 carry untouched");
    // R8 subtract
    step(8'hC5, 8'h12, "R8 sub borrow");
    showReg(5, "R8 sub result borrow");
    showCarry("R8 carry on borrow");
    step(8'hC6, 8'h21, "R8 sub no borrow");
    showReg(6, "R8 sub result");
    showCarry("R8 carry no borrow");
    step(8'hC6, 8'h11, "R8 sub equal operands");
    showCarry("R8 carry equal operands");
    // R9 increment
    step(8'h17, 8'hFF, "R9 load ff");
    step(8'hE8, 8'h70, "R9 inc wrap");
    showReg(8, "R9 inc wrap result");
    showCarry("R9 inc wrap carry");
    step(8'hE8, 8'h10, "R9 inc plain");
    showReg(8, "R9 inc result");
    showCarry("R9 inc carry clear");
    // R6 logic ops clear carry
    step(8'hB9, 8'h77, "R6 set carry first");
    step(8'h89, 8'h10, "R6 not");
    showReg(9, "R6 not result");
    showCarry("R6 not clears carry");
    step(8'h99, 8'h12, "R6 and");
    showReg(9, "R6 and result");
    step(8'hA9, 8'h12, "R6 or");
    showReg(9, "R6 or result");
    step(8'hD9, 8'h12, "R6 xor");
    showReg(9, "R6 xor result");
    showCarry("R6 carry after logic");
    // R12 destination aliasing a source
    step(8'hB1, 8'h11, "R12 add r1=r1+r1");
    showReg(1, "R12 aliased add");
    step(8'hC2, 8'h21, "R12 sub r2=r2-r1");
    showReg(2, "R12 aliased sub");
    // R5 status after set carry
    step(8'h1A, 8'h80, "R5 load 80");
    step(8'hBB, 8'hAA, "R5 add overflow exact");
    showCarry("R5 status bit0 set");
    // random stream
    for (int n = 0; n < 600; n++) begin
      step(8'($urandom), 8'($urandom), "R2-R12 random stream");
    end
    for (int i = 0; i < 16; i++) showReg(i, "R3 final register dump");
    rst = 1'b1;
    for (int i = 0; i < 16; i++) mRegs[i] = 0;
    mCarry = 0;
    mOut   = 0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R1 reset mid-run");
    showCarry("R1 carry cleared mid-run");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule